// File: doc/BRIEF.md
# Aliased Nibble RAM Address Unit

This block holds a small scratch memory of 4-bit digits: four registers of eight digits each, 128 bits in all. A 6-bit pointer selects the current digit. The upper 2 bits of the pointer pick the register. The lower 4 bits form a digit field. Only the three low bits of that field reach the memory, so every physical digit answers to two pointer values. An external decoder issues one operation per clock on `op_i`. The operation can read the addressed digit, store the accumulator nibble into it, swap it with the accumulator, or load it from either half of an 8-bit port. It can also step the digit field up or down, reload part or all of the pointer, or reach one fixed digit directly without using the pointer.

Stepping the digit field raises a one-cycle skip flag only when the 4-bit field wraps between 15 and 0. Moving between 7 and 8 changes the field's top bit but never skips, even though it is where the physical digit index wraps. All outputs are registered. A read value appears on `rdata_o` one clock after the operation, together with `rvalid_o`.

Top module: `nibble_ram_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `ptr_o`=0, `skip_o`=0 and `rvalid_o`=0; memory contents are not reset.
- R2: Opcode 1 (read) gives the digit at physical index {ptr[5:4], ptr[2:0]} on `rdata_o` in the following cycle, with `rvalid_o`=1.
- R3: Pointer bit 3 plays no part in digit selection: a digit written with bit 3 at 1 reads back with bit 3 at 0, and the reverse also holds.
- R4: Opcode 2 (store) writes `acc_i` into the addressed digit.
- R5: Opcode 3 (exchange) acts in one cycle: `rdata_o` gives the old digit and the digit takes `acc_i`.
- R6: Opcode 4 (port load) writes `port_i[3:0]` into the addressed digit when `half_i`=0, and `port_i[7:4]` when `half_i`=1.
- R7: Opcode 5 (step up) adds 1 modulo 16 to `ptr_o[3:0]` and leaves `ptr_o[5:4]` unchanged. `skip_o` is 1 in the next cycle exactly when the old field was 15.
- R8: Opcode 6 (step down) subtracts 1 modulo 16 from `ptr_o[3:0]` and leaves `ptr_o[5:4]` unchanged. `skip_o` is 1 exactly when the old field was 0, so a move from 8 to 7 does not skip.
- R9: Opcode 7 loads `acc_i` into `ptr_o[3:0]` and keeps `ptr_o[5:4]`.
- R10: Opcode 8 loads all six pointer bits from `imm_i`.
- R11: Opcodes 9 (direct read) and 10 (direct exchange) reach the fixed digit at physical index 31 (pointer value 6'h3F) whatever the pointer holds, and leave the pointer unchanged.
- R12: Opcode 0 and opcodes 11 to 15 change neither the pointer nor the memory. After every opcode other than 5 and 6, `skip_o` is 0. After every opcode other than 1, 3, 9 and 10, `rvalid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code for this cycle |
| acc_i | input | 4 | Accumulator nibble |
| imm_i | input | 6 | Immediate pointer value |
| port_i | input | 8 | External port data |
| half_i | input | 1 | Selects the port half for a port load |
| ptr_o | output | 6 | Current pointer |
| skip_o | output | 1 | Wrap skip from the last step operation |
| rdata_o | output | 4 | Digit read by the last read-type operation |
| rvalid_o | output | 1 | `rdata_o` is valid this cycle |

## Verification
The assertions assume that `op_i` is a known 4-bit value at every clock edge. The stimulus meets this by driving every opcode, including the unused codes, on the falling edge only. The data checks also need every digit to be written before it is read. The bench writes all 32 physical digits through aliased pointer values before it checks any read, and it then draws random operations that land on both aliases of each digit.

// File: rtl/nram_pkg.sv
package nram_pkg;
  typedef enum logic [3:0] {
    OP_NOP   = 4'd0,
    OP_READ  = 4'd1,
    OP_STORE = 4'd2,
    OP_SWAP  = 4'd3,
    OP_PORT  = 4'd4,
    OP_UP    = 4'd5,
    OP_DOWN  = 4'd6,
    OP_FLD   = 4'd7,
    OP_PTR   = 4'd8,
    OP_DRD   = 4'd9,
    OP_DSWAP = 4'd10
  } nram_op_e;
endpackage

// File: rtl/nram_ptr.sv
module nram_ptr
  import nram_pkg::*;
#(
  parameter int REG_W = 2,
  parameter int FLD_W = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  nram_op_e               op,
  input  logic [FLD_W-1:0]       fld_load,
  input  logic [REG_W+FLD_W-1:0] ptr_load,
  output logic [REG_W+FLD_W-1:0] ptr_q,
  output logic                   skip_q
);
  logic [FLD_W-1:0] fld;
  assign fld = ptr_q[FLD_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      skip_q <= 1'b0;
    end else begin
      skip_q <= 1'b0;
      case (op)
        OP_UP: begin
          ptr_q[FLD_W-1:0] <= fld + 1'b1;
          skip_q           <= (fld == '1);
        end
        OP_DOWN: begin
          ptr_q[FLD_W-1:0] <= fld - 1'b1;
          skip_q           <= (fld == '0);
        end
        OP_FLD:  ptr_q[FLD_W-1:0] <= fld_load;
        OP_PTR:  ptr_q            <= ptr_load;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/nram_amap.sv
module nram_amap #(
  parameter int REG_W   = 2,
  parameter int SEL_W   = 3,
  parameter int DIR_PTR = 63
) (
  input  logic [REG_W+SEL_W:0]   ptr,
  input  logic                   direct,
  output logic [REG_W+SEL_W-1:0] phys
);
  localparam int FLD_W = SEL_W + 1;
  localparam int PW    = REG_W + FLD_W;
  localparam logic [PW-1:0] DIR_V = PW'(DIR_PTR);
  localparam logic [REG_W+SEL_W-1:0] DIR_PHYS = {DIR_V[PW-1:FLD_W], DIR_V[SEL_W-1:0]};

  always_comb begin
    if (direct) phys = DIR_PHYS;
    else        phys = {ptr[PW-1:FLD_W], ptr[SEL_W-1:0]};
  end
endmodule

// File: rtl/nram_store.sv
module nram_store #(
  parameter int DW = 4,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/nibble_ram_unit.sv
module nibble_ram_unit
  import nram_pkg::*;
#(
  parameter int DIG_W   = 4,
  parameter int REG_W   = 2,
  parameter int SEL_W   = 3,
  parameter int DIR_PTR = 63
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [3:0]             op_i,
  input  logic [DIG_W-1:0]       acc_i,
  input  logic [REG_W+SEL_W:0]   imm_i,
  input  logic [2*DIG_W-1:0]     port_i,
  input  logic                   half_i,
  output logic [REG_W+SEL_W:0]   ptr_o,
  output logic                   skip_o,
  output logic [DIG_W-1:0]       rdata_o,
  output logic                   rvalid_o
);
  localparam int FLD_W = SEL_W + 1;
  localparam int AW    = REG_W + SEL_W;

  nram_op_e         op;
  logic             we, re, direct;
  logic [AW-1:0]    phys;
  logic [DIG_W-1:0] wdata, port_nib;
  logic [FLD_W-1:0] fld_load;

  assign op       = nram_op_e'(op_i);
  assign fld_load = FLD_W'(acc_i);
  assign port_nib = half_i ? port_i[2*DIG_W-1:DIG_W] : port_i[DIG_W-1:0];

  always_comb begin
    we = 1'b0; re = 1'b0; direct = 1'b0;
    case (op)
      OP_READ:  re = 1'b1;
      OP_STORE: we = 1'b1;
      OP_SWAP:  begin we = 1'b1; re = 1'b1; end
      OP_PORT:  we = 1'b1;
      OP_DRD:   begin re = 1'b1; direct = 1'b1; end
      OP_DSWAP: begin we = 1'b1; re = 1'b1; direct = 1'b1; end
      default: ;
    endcase
    wdata = (op == OP_PORT) ? port_nib : acc_i;
  end

  nram_ptr #(.REG_W(REG_W), .FLD_W(FLD_W)) u_ptr (
    .clk(clk), .rst(rst), .op(op), .fld_load(fld_load),
    .ptr_load(imm_i), .ptr_q(ptr_o), .skip_q(skip_o)
  );

  nram_amap #(.REG_W(REG_W), .SEL_W(SEL_W), .DIR_PTR(DIR_PTR)) u_amap (
    .ptr(ptr_o), .direct(direct), .phys(phys)
  );

  nram_store #(.DW(DIG_W), .AW(AW)) u_store (
    .clk(clk), .we(we), .re(re), .addr(phys), .wdata(wdata), .rdata(rdata_o)
  );

  always_ff @(posedge clk) begin
    if (rst) rvalid_o <= 1'b0;
    else     rvalid_o <= re;
  end
endmodule

// File: rtl/nibble_ram_unit_chk.sv
module nibble_ram_unit_chk #(
  parameter int PW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic [3:0]    op_i,
  input logic [3:0]    acc_i,
  input logic [PW-1:0] imm_i,
  input logic [PW-1:0] ptr_o,
  input logic          skip_o,
  input logic          rvalid_o
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (ptr_o == '0 && !skip_o && !rvalid_o)); // R1
  AST_READ_VALID: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd1 || op_i == 4'd3 || op_i == 4'd9 || op_i == 4'd10) |=> rvalid_o); // R2
  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    op_i == 4'd5 |=> (ptr_o[3:0] == 4'($past(ptr_o[3:0]) + 4'd1) && ptr_o[PW-1:4] == $past(ptr_o[PW-1:4]))); // R7
  AST_UP_SKIP: assert property (@(posedge clk) disable iff (rst)
    op_i == 4'd5 |=> skip_o == ($past(ptr_o[3:0]) == 4'd15)); // R7
  AST_DOWN_SKIP: assert property (@(posedge clk) disable iff (rst)
    op_i == 4'd6 |=> skip_o == ($past(ptr_o[3:0]) == 4'd0)); // R8
  AST_FLD_LOAD: assert property (@(posedge clk) disable iff (rst)
    op_i == 4'd7 |=> (ptr_o[3:0] == $past(acc_i) && ptr_o[PW-1:4] == $past(ptr_o[PW-1:4]))); // R9
  AST_PTR_LOAD: assert property (@(posedge clk) disable iff (rst)
    op_i == 4'd8 |=> ptr_o == $past(imm_i)); // R10
  AST_DIRECT_KEEPS_PTR: assert property (@(posedge clk) disable iff (rst)
    (op_i == 4'd9 || op_i == 4'd10) |=> $stable(ptr_o)); // R11
  AST_NO_STRAY_SKIP: assert property (@(posedge clk) disable iff (rst)
    (op_i != 4'd5 && op_i != 4'd6) |=> !skip_o); // R12
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (rst)
    (op_i != 4'd1 && op_i != 4'd3 && op_i != 4'd9 && op_i != 4'd10) |=> !rvalid_o); // R12
endmodule

bind nibble_ram_unit nibble_ram_unit_chk #(.PW(REG_W + SEL_W + 1)) u_chk (
  .clk(clk), .rst(rst), .op_i(op_i), .acc_i(acc_i), .imm_i(imm_i),
  .ptr_o(ptr_o), .skip_o(skip_o), .rvalid_o(rvalid_o)
);

// File: tb/sim_nibble_ram_unit.sv
`timescale 1ns/1ps
module sim_nibble_ram_unit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] op_i = '0, acc_i = '0;
  logic [5:0] imm_i = '0;
  logic [7:0] port_i = '0;
  logic       half_i = 1'b0;
  logic [5:0] ptr_o;
  logic       skip_o, rvalid_o;
  logic [3:0] rdata_o;

  int total = 0, bad = 0;
  logic [5:0] m_ptr;
  logic [3:0] m_mem [32];

  always #2.5 clk = ~clk;

  nibble_ram_unit u0 (
    .clk(clk), .rst(rst), .op_i(op_i), .acc_i(acc_i), .imm_i(imm_i),
    .port_i(port_i), .half_i(half_i), .ptr_o(ptr_o), .skip_o(skip_o),
    .rdata_o(rdata_o), .rvalid_o(rvalid_o)
  );

  function automatic logic [4:0] phys_of(logic [5:0] p);
    return {p[5:4], p[2:0]};
  endfunction

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'd1: return "R2"; 4'd2: return "R4"; 4'd3: return "R5";
      4'd4: return "R6"; 4'd5: return "R7"; 4'd6: return "R8";
      4'd7: return "R9"; 4'd8: return "R10"; 4'd9, 4'd10: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] op, input logic [3:0] acc, input logic [5:0] imm,
                       input logic [7:0] port, input logic half, input string req);
    logic [5:0] np;
    logic       exp_skip, exp_vld;
    logic [3:0] exp_data, wv;
    logic [4:0] pa;
    @(negedge clk);
    op_i = op; acc_i = acc; imm_i = imm; port_i = port; half_i = half;
    np = m_ptr; exp_skip = 1'b0; exp_vld = 1'b0; exp_data = '0;
    pa = (op == 4'd9 || op == 4'd10) ? 5'd31 : phys_of(m_ptr);
    wv = half ? port[7:4] : port[3:0];
    case (op)
      4'd1: begin exp_vld = 1'b1; exp_data = m_mem[pa]; end
      4'd2: m_mem[pa] = acc;
      4'd3, 4'd10: begin exp_vld = 1'b1; exp_data = m_mem[pa]; m_mem[pa] = acc; end
      4'd4: m_mem[pa] = wv;
      4'd5: begin np[3:0] = m_ptr[3:0] + 4'd1; exp_skip = (m_ptr[3:0] == 4'd15); end
      4'd6: begin np[3:0] = m_ptr[3:0] - 4'd1; exp_skip = (m_ptr[3:0] == 4'd0); end
      4'd7: np[3:0] = acc;
      4'd8: np = imm;
      4'd9: begin exp_vld = 1'b1; exp_data = m_mem[pa]; end
      default: ;
    endcase
    m_ptr = np;
    @(posedge clk); #1;
    check(req, "ptr", int'(ptr_o), int'(np));
    check(req, "skip", int'(skip_o), int'(exp_skip));
    check(req, "valid", int'(rvalid_o), int'(exp_vld));
    if (exp_vld) check(req, "data", int'(rdata_o), int'(exp_data));
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_ptr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    check("R1", "reset ptr", int'(ptr_o), 0);
    check("R1", "reset skip", int'(skip_o), 0);
    check("R1", "reset valid", int'(rvalid_o), 0);

    // R3 / R4: fill every digit through the alias with pointer bit 3 set
    for (int i = 0; i < 32; i++) begin
      do_op(4'd8, 4'd0, {i[4:3], 1'b1, i[2:0]}, 8'h0, 1'b0, "R10");
      do_op(4'd2, 4'(i * 7 + 3), 6'd0, 8'h0, 1'b0, "R4");
    end
    // R3: read back with bit 3 clear
    for (int i = 0; i < 32; i++) begin
      do_op(4'd8, 4'd0, {i[4:3], 1'b0, i[2:0]}, 8'h0, 1'b0, "R10");
      do_op(4'd1, 4'd0, 6'd0, 8'h0, 1'b0, "R3");
    end
    // R7: 7->8 without skip, 15->0 with skip, register field kept
    do_op(4'd8, 4'd0, 6'h27, 8'h0, 1'b0, "R10");
    do_op(4'd5, 4'd0, 6'd0, 8'h0, 1'b0, "R7");
    do_op(4'd8, 4'd0, 6'h2F, 8'h0, 1'b0, "R10");
    do_op(4'd5, 4'd0, 6'd0, 8'h0, 1'b0, "R7");
    // R8: 8->7 without skip, 0->15 with skip
    do_op(4'd8, 4'd0, 6'h18, 8'h0, 1'b0, "R10");
    do_op(4'd6, 4'd0, 6'd0, 8'h0, 1'b0, "R8");
    do_op(4'd8, 4'd0, 6'h10, 8'h0, 1'b0, "R10");
    do_op(4'd6, 4'd0, 6'd0, 8'h0, 1'b0, "R8");
    // R6: both port halves
    do_op(4'd4, 4'd0, 6'd0, 8'hA5, 1'b0, "R6");
    do_op(4'd1, 4'd0, 6'd0, 8'h0, 1'b0, "R6");
    do_op(4'd4, 4'd0, 6'd0, 8'hC3, 1'b1, "R6");
    do_op(4'd1, 4'd0, 6'd0, 8'h0, 1'b0, "R6");
    // R5: exchange twice returns the first value
    do_op(4'd3, 4'd9, 6'd0, 8'h0, 1'b0, "R5");
    do_op(4'd3, 4'd2, 6'd0, 8'h0, 1'b0, "R5");
    // R9 then R11: direct access with pointer elsewhere
    do_op(4'd7, 4'd6, 6'd0, 8'h0, 1'b0, "R9");
    do_op(4'd10, 4'd1, 6'd0, 8'h0, 1'b0, "R11");
    do_op(4'd9, 4'd0, 6'd0, 8'h0, 1'b0, "R11");
    do_op(4'd8, 4'd0, 6'h37, 8'h0, 1'b0, "R10");
    do_op(4'd1, 4'd0, 6'd0, 8'h0, 1'b0, "R11");
    // R12: unused codes leave pointer and digit alone
    for (int c = 11; c < 16; c++) do_op(4'(c), 4'hF, 6'h3F, 8'hFF, 1'b1, "R12");
    do_op(4'd0, 4'hF, 6'h00, 8'hFF, 1'b0, "R12");
    do_op(4'd1, 4'd0, 6'd0, 8'h0, 1'b0, "R12");

    for (int n = 0; n < 4000; n++) begin
      logic [3:0] rop;
      rop = 4'($urandom_range(0, 15));
      do_op(rop, 4'($urandom), 6'($urandom), 8'($urandom), 1'($urandom), req_of(rop));
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule